// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard control for a five-stage in-order pipeline made of fetch, decode with register read, execute, memory access and write-back stages. It observes the register specifiers and the few control bits held in the three pipeline registers behind decode. From these it steers the two execute-stage operand multiplexers to the newest copy of each source register, so a chain of ALU instructions runs back to back with no lost cycle.

A load delivers its data only at the end of the memory stage. When the instruction right behind a load reads the load's destination, the block raises one cycle of interlock. During that cycle the program counter and the fetch/decode register hold their values, and the decode/execute register is loaded with a cleared control word. That word then moves through execute, memory and write-back as a bubble that writes nothing. On the next cycle the consumer enters execute and takes the loaded value from the write-back stage through forwarding.

The block also contains the architectural register file. Its two read ports bypass a write-back that targets the same register in the same cycle, so a producer three instructions ahead of its consumer needs no forwarding path.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When the EX/MEM producer writes a nonzero register equal to an execute-stage source, that operand's select is 2'b10.
- R2: When only the MEM/WB producer writes a nonzero register equal to an execute-stage source, that operand's select is 2'b01.
- R3: When both the EX/MEM and MEM/WB producers match the same source, the EX/MEM result wins and the select is 2'b10.
- R4: A source of register 0, or a producer with its write enable low, never selects forwarding; the select is then 2'b00, meaning the register file value.
- R5: When the ID/EX instruction is a load (memory read and register write both set) with a nonzero destination equal to a used decode source, pc_hold, ifid_hold and idex_bubble are all 1 in that cycle.
- R6: No stall is raised when the ID/EX instruction is not a load, when its destination is register 0, or when the matching decode source is flagged as unused.
- R7: A read of register r in the cycle in which write-back writes a nonzero r returns the write-back data.
- R8: A completed write is returned by later reads. Register 0 always reads zero, and a write-back with its enable low changes nothing.
- R9: After reset every register reads zero, both selects are 2'b00 and all three stall outputs are 0.
- R10: A full load-use sequence behaves as one stall cycle, then no stall while the bubble is in execute, then select 2'b01 for the consumer in execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | AW | Decode-stage first source register |
| id_rs2 | input | AW | Decode-stage second source register |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| ex_rs1 | input | AW | ID/EX first source register |
| ex_rs2 | input | AW | ID/EX second source register |
| ex_rd | input | AW | ID/EX destination register |
| ex_mem_read | input | 1 | ID/EX instruction reads data memory |
| ex_reg_write | input | 1 | ID/EX instruction writes a register |
| mem_rd | input | AW | EX/MEM destination register |
| mem_reg_write | input | 1 | EX/MEM instruction writes a register |
| wb_rd | input | AW | MEM/WB destination register |
| wb_reg_write | input | 1 | MEM/WB instruction writes a register |
| wb_data | input | XLEN | Write-back data |
| fwd_a_sel | output | 2 | First operand select: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_b_sel | output | 2 | Second operand select, same encoding |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the IF/ID register |
| idex_bubble | output | 1 | Load cleared control into ID/EX |
| rd_data1 | output | XLEN | Register file read data for id_rs1 |
| rd_data2 | output | XLEN | Register file read data for id_rs2 |

## Verification
The hardest case to reach is the complete load-use sequence, because the stall, the bubble and the later forwarding span three cycles in which every pipeline register field has to move consistently. The bench plays the role of the pipeline: it advances the IF/ID, ID/EX, EX/MEM and MEM/WB fields by hand each cycle, puts a cleared control word into ID/EX when the stall is seen, and checks the stall outputs and the operand select at each step. Same-cycle register bypass is reached by holding a write-back and a decode read of the same register before the clock edge.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    sel
);
  logic     src_nz;
  logic     hit_mem;
  logic     hit_wb;
  fwd_sel_e choice;

  always_comb begin
    src_nz  = (src != '0);
    hit_mem = src_nz && mem_we && (mem_rd == src);
    hit_wb  = src_nz && wb_we && (wb_rd == src);
    // the younger producer sits in EX/MEM and takes priority
    if (hit_mem)     choice = SEL_MEM;
    else if (hit_wb) choice = SEL_WB;
    else             choice = SEL_REGFILE;
    sel = choice;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use_rs1,
  input  logic          id_use_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_mem_read,
  input  logic          ex_reg_write,
  output logic          stall
);
  logic is_load;
  logic dep1;
  logic dep2;

  always_comb begin
    is_load = ex_mem_read && ex_reg_write && (ex_rd != '0);
    dep1    = id_use_rs1 && (id_rs1 == ex_rd);
    dep2    = id_use_rs2 && (id_rs2 == ex_rd);
    stall   = is_load && (dep1 || dep2);
  end
endmodule

// File: rtl/hz_regfile.sv
module hz_regfile #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            wr_addr,
  input  logic                     wr_en,
  input  logic [XLEN-1:0]          wr_data,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][XLEN-1:0] rd_data
);
  logic [XLEN-1:0] regs [NREGS];
  logic            wr_ok;

  always_comb wr_ok = wr_en && (wr_addr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_ok) begin
      regs[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_addr[p] == '0)
        rd_data[p] = '0;
      else if (wr_ok && (wr_addr == rd_addr[p]))
        rd_data[p] = wr_data;
      else
        rd_data[p] = regs[rd_addr[p]];
    end
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   id_rs1,
  input  logic [AW-1:0]   id_rs2,
  input  logic            id_use_rs1,
  input  logic            id_use_rs2,
  input  logic [AW-1:0]   ex_rs1,
  input  logic [AW-1:0]   ex_rs2,
  input  logic [AW-1:0]   ex_rd,
  input  logic            ex_mem_read,
  input  logic            ex_reg_write,
  input  logic [AW-1:0]   mem_rd,
  input  logic            mem_reg_write,
  input  logic [AW-1:0]   wb_rd,
  input  logic            wb_reg_write,
  input  logic [XLEN-1:0] wb_data,
  output logic [1:0]      fwd_a_sel,
  output logic [1:0]      fwd_b_sel,
  output logic            pc_hold,
  output logic            ifid_hold,
  output logic            idex_bubble,
  output logic [XLEN-1:0] rd_data1,
  output logic [XLEN-1:0] rd_data2
);
  localparam int NOPS = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [NOPS-1:0][AW-1:0] ex_src;
  logic [NOPS-1:0][1:0]    sel;
  logic [NOPS-1:0][AW-1:0] rf_addr;
  logic [NOPS-1:0][XLEN-1:0] rf_data;
  logic                    lu_stall;

  always_comb begin
    ex_src[0]  = ex_rs1;
    ex_src[1]  = ex_rs2;
    rf_addr[0] = id_rs1;
    rf_addr[1] = id_rs2;
  end

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    hz_fwd_sel #(.AW(AW)) u_fwd (
      .src    (ex_src[k]),
      .mem_rd (mem_rd),
      .mem_we (mem_reg_write),
      .wb_rd  (wb_rd),
      .wb_we  (wb_reg_write),
      .sel    (sel[k])
    );
  end

  hz_load_use #(.AW(AW)) u_lu (
    .id_rs1       (id_rs1),
    .id_rs2       (id_rs2),
    .id_use_rs1   (id_use_rs1),
    .id_use_rs2   (id_use_rs2),
    .ex_rd        (ex_rd),
    .ex_mem_read  (ex_mem_read),
    .ex_reg_write (ex_reg_write),
    .stall        (lu_stall)
  );

  hz_regfile #(.NREGS(NREGS), .XLEN(XLEN), .NRD(NOPS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_addr (wb_rd),
    .wr_en   (wb_reg_write),
    .wr_data (wb_data),
    .rd_addr (rf_addr),
    .rd_data (rf_data)
  );

  always_comb begin
    fwd_a_sel   = sel[0];
    fwd_b_sel   = sel[1];
    pc_hold     = lu_stall;
    ifid_hold   = lu_stall;
    idex_bubble = lu_stall;
    rd_data1    = rf_data[0];
    rd_data2    = rf_data[1];
  end
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int AW   = 5,
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   id_rs1,
  input logic            id_use_rs1,
  input logic [AW-1:0]   ex_rs1,
  input logic [AW-1:0]   ex_rd,
  input logic            ex_mem_read,
  input logic [AW-1:0]   mem_rd,
  input logic            mem_reg_write,
  input logic            wb_reg_write,
  input logic [AW-1:0]   wb_rd,
  input logic [XLEN-1:0] wb_data,
  input logic [1:0]      fwd_a_sel,
  input logic [1:0]      fwd_b_sel,
  input logic            pc_hold,
  input logic            ifid_hold,
  input logic            idex_bubble,
  input logic [XLEN-1:0] rd_data1
);
  assert_mem_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_reg_write && ex_rs1 != '0 && mem_rd == ex_rs1) |-> fwd_a_sel == 2'b10);

  assert_wb_needs_we_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel == 2'b01) |-> (wb_reg_write && wb_rd == ex_rs1));

  assert_no_illegal_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));

  assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == '0) |-> fwd_a_sel == 2'b00);

  assert_stall_is_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_hold || ifid_hold || idex_bubble) |-> (ex_mem_read && ex_rd != '0));

  assert_stall_on_dep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_read && idex_bubble == 1'b0 && id_use_rs1 && ex_rd != '0 && id_rs1 == ex_rd)
      |-> 1'b0 == (pc_hold ^ ifid_hold));

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_reg_write && wb_rd != '0 && wb_rd == id_rs1) |-> rd_data1 == wb_data);

  assert_zero_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0) |-> rd_data1 == '0);
endmodule

bind pipe_hazard_ctrl hz_checker #(.AW(AW), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_use_rs1(id_use_rs1),
  .ex_rs1(ex_rs1), .ex_rd(ex_rd), .ex_mem_read(ex_mem_read),
  .mem_rd(mem_rd), .mem_reg_write(mem_reg_write),
  .wb_reg_write(wb_reg_write), .wb_rd(wb_rd), .wb_data(wb_data),
  .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .pc_hold(pc_hold),
  .ifid_hold(ifid_hold), .idex_bubble(idex_bubble), .rd_data1(rd_data1)
);

// File: tb/pipe_hazard_ctrl_tb.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_tb;
  localparam int AW   = 5;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use_rs1, id_use_rs2, ex_mem_read, ex_reg_write, mem_reg_write, wb_reg_write;
  logic [XLEN-1:0] wb_data;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic pc_hold, ifid_hold, idex_bubble;
  logic [XLEN-1:0] rd_data1, rd_data2;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  pipe_hazard_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .ex_rs1(ex_rs1),
    .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_mem_read(ex_mem_read),
    .ex_reg_write(ex_reg_write), .mem_rd(mem_rd), .mem_reg_write(mem_reg_write),
    .wb_rd(wb_rd), .wb_reg_write(wb_reg_write), .wb_data(wb_data),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .pc_hold(pc_hold),
    .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
    .rd_data1(rd_data1), .rd_data2(rd_data2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    id_rs1 = '0; id_rs2 = '0; id_use_rs1 = 1'b0; id_use_rs2 = 1'b0;
    ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_mem_read = 1'b0; ex_reg_write = 1'b0;
    mem_rd = '0; mem_reg_write = 1'b0; wb_rd = '0; wb_reg_write = 1'b0; wb_data = '0;
  endtask

  // drive at the falling edge, sample 1 ns later
  task automatic step();
    @(negedge clk);
  endtask

  task automatic stall_word(output logic [2:0] w);
    w = {pc_hold, ifid_hold, idex_bubble};
  endtask

  task automatic t_reset();
    logic [2:0] w;
    idle_all();
    id_rs1 = 5'd7; id_rs2 = 5'd31;
    #1;
    chk("R9 rd_data1", rd_data1, 32'h0);
    chk("R9 rd_data2", rd_data2, 32'h0);
    chk("R9 fwd_a_sel", {30'b0, fwd_a_sel}, 32'h0);
    chk("R9 fwd_b_sel", {30'b0, fwd_b_sel}, 32'h0);
    stall_word(w);
    chk("R9 stall", {29'b0, w}, 32'h0);
  endtask

  task automatic t_fwd_mem();
    step(); idle_all();
    ex_rs1 = 5'd3; ex_rs2 = 5'd9; mem_rd = 5'd3; mem_reg_write = 1'b1;
    #1;
    chk("R1 a from EX/MEM", {30'b0, fwd_a_sel}, 32'h2);
    chk("R1 b untouched", {30'b0, fwd_b_sel}, 32'h0);
    ex_rs1 = 5'd4; ex_rs2 = 5'd3;
    #1;
    chk("R1 b from EX/MEM", {30'b0, fwd_b_sel}, 32'h2);
  endtask

  task automatic t_fwd_wb();
    step(); idle_all();
    ex_rs1 = 5'd12; ex_rs2 = 5'd12; wb_rd = 5'd12; wb_reg_write = 1'b1;
    mem_rd = 5'd13; mem_reg_write = 1'b1; wb_data = 32'h55;
    #1;
    chk("R2 a from MEM/WB", {30'b0, fwd_a_sel}, 32'h1);
    chk("R2 b from MEM/WB", {30'b0, fwd_b_sel}, 32'h1);
  endtask

  task automatic t_priority();
    step(); idle_all();
    ex_rs1 = 5'd6; ex_rs2 = 5'd6; mem_rd = 5'd6; mem_reg_write = 1'b1;
    wb_rd = 5'd6; wb_reg_write = 1'b1; wb_data = 32'h66;
    #1;
    chk("R3 a EX/MEM wins", {30'b0, fwd_a_sel}, 32'h2);
    chk("R3 b EX/MEM wins", {30'b0, fwd_b_sel}, 32'h2);
  endtask

  task automatic t_no_fwd();
    step(); idle_all();
    ex_rs1 = 5'd0; ex_rs2 = 5'd0; mem_rd = 5'd0; mem_reg_write = 1'b1;
    wb_rd = 5'd0; wb_reg_write = 1'b1;
    #1;
    chk("R4 r0 a", {30'b0, fwd_a_sel}, 32'h0);
    chk("R4 r0 b", {30'b0, fwd_b_sel}, 32'h0);
    ex_rs1 = 5'd8; ex_rs2 = 5'd8; mem_rd = 5'd8; mem_reg_write = 1'b0;
    wb_rd = 5'd8; wb_reg_write = 1'b0;
    #1;
    chk("R4 disabled a", {30'b0, fwd_a_sel}, 32'h0);
    chk("R4 disabled b", {30'b0, fwd_b_sel}, 32'h0);
  endtask

  task automatic t_load_use();
    logic [2:0] w;
    step(); idle_all();
    // rs2 dependence
    ex_rd = 5'd10; ex_mem_read = 1'b1; ex_reg_write = 1'b1;
    id_rs1 = 5'd1; id_rs2 = 5'd10; id_use_rs1 = 1'b1; id_use_rs2 = 1'b1;
    #1; stall_word(w);
    chk("R5 stall on rs2", {29'b0, w}, 32'h7);
    id_rs1 = 5'd10; id_rs2 = 5'd2;
    #1; stall_word(w);
    chk("R5 stall on rs1", {29'b0, w}, 32'h7);
  endtask

  task automatic t_no_stall();
    logic [2:0] w;
    step(); idle_all();
    ex_rd = 5'd10; ex_reg_write = 1'b1; ex_mem_read = 1'b0;
    id_rs1 = 5'd10; id_use_rs1 = 1'b1;
    #1; stall_word(w);
    chk("R6 ALU producer", {29'b0, w}, 32'h0);
    ex_mem_read = 1'b1; id_use_rs1 = 1'b0;
    #1; stall_word(w);
    chk("R6 source unused", {29'b0, w}, 32'h0);
    id_use_rs1 = 1'b1; id_rs1 = 5'd11;
    #1; stall_word(w);
    chk("R6 other register", {29'b0, w}, 32'h0);
    ex_rd = 5'd0; id_rs1 = 5'd0;
    #1; stall_word(w);
    chk("R6 load to r0", {29'b0, w}, 32'h0);
  endtask

  task automatic t_sequence();
    logic [2:0] w;
    // cycle 1: load r14 in ID/EX, consumer reads r14 in decode
    step(); idle_all();
    ex_rd = 5'd14; ex_mem_read = 1'b1; ex_reg_write = 1'b1;
    id_rs1 = 5'd14; id_use_rs1 = 1'b1;
    #1; stall_word(w);
    chk("R10 stall cycle", {29'b0, w}, 32'h7);
    // cycle 2: bubble in ID/EX, load in EX/MEM, consumer held in decode
    step();
    ex_rd = 5'd0; ex_mem_read = 1'b0; ex_reg_write = 1'b0;
    mem_rd = 5'd14; mem_reg_write = 1'b1;
    #1; stall_word(w);
    chk("R10 bubble cycle no stall", {29'b0, w}, 32'h0);
    // cycle 3: consumer in EX, bubble in EX/MEM, load in MEM/WB
    step();
    ex_rs1 = 5'd14; mem_rd = 5'd0; mem_reg_write = 1'b0;
    wb_rd = 5'd14; wb_reg_write = 1'b1; wb_data = 32'hABCD;
    id_rs1 = 5'd0; id_use_rs1 = 1'b0;
    #1;
    chk("R10 forward loaded value", {30'b0, fwd_a_sel}, 32'h1);
  endtask

  task automatic t_regfile();
    step(); idle_all();
    wb_rd = 5'd20; wb_reg_write = 1'b1; wb_data = 32'hDEAD_BEEF;
    id_rs1 = 5'd20; id_rs2 = 5'd21;
    #1;
    chk("R7 same-cycle bypass", rd_data1, 32'hDEAD_BEEF);
    chk("R7 other port unaffected", rd_data2, 32'h0);
    step();
    wb_rd = 5'd21; wb_data = 32'h1234_5678;
    step();
    wb_reg_write = 1'b0; wb_rd = 5'd20; wb_data = 32'hFFFF_FFFF;
    #1;
    chk("R8 stored r20", rd_data1, 32'hDEAD_BEEF);
    chk("R8 stored r21", rd_data2, 32'h1234_5678);
    step();
    #1;
    chk("R8 disabled write ignored", rd_data1, 32'hDEAD_BEEF);
    wb_rd = 5'd0; wb_reg_write = 1'b1; wb_data = 32'h9999;
    id_rs1 = 5'd0;
    step();
    wb_reg_write = 1'b0;
    #1;
    chk("R8 r0 reads zero", rd_data1, 32'h0);
  endtask

  initial begin
    idle_all();
    rst_n = 1'b0;
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_fwd_mem();
    t_fwd_wb();
    t_priority();
    t_no_fwd();
    t_load_use();
    t_no_stall();
    t_sequence();
    t_regfile();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #20000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule